// File: doc/BRIEF.md
# Ethernet Layer-2 Learning Forwarder

This block makes the per-frame forwarding decision for a small Ethernet switch, and learns station addresses while it does so. Each accepted descriptor carries a 48-bit destination address, a 48-bit source address and the number of the port the frame came in on. The destination address is searched in a small associative table of address-to-port bindings, and the block returns a bitmap of egress ports. A known destination goes to its single stored port. An unknown destination is flooded to every port except the ingress port. A destination equal to the switch's own address is sent to the local processor and to no port.

The source address is searched in the same table at the same time. When the source is absent, a binding to the ingress port is written into the lowest free slot. When the source is present but now arrives on another port, its binding moves to that port. When the table is full, the new address is dropped and a saturating counter records the loss. Both searches of one frame see the table as it stood before that frame. The result is registered and appears one cycle after the descriptor is accepted.

Top module: `l2_learn_fwd`

## Requirements
- R1: `desc_ready` is high whenever the block is out of reset. `res_valid` is high in exactly the cycle after a cycle in which `desc_valid` and `desc_ready` were both high, and is low otherwise.
- R2: When the destination matches a table entry (and is not the own address), `res_hit` is 1, `res_to_cpu` is 0, and `res_egress` has only bit p set, where p is the port stored in that entry. Bit i of `res_egress` stands for port i.
- R3: When the destination matches no entry (and is not the own address), `res_hit` is 0, `res_to_cpu` is 0, and `res_egress` has every bit set except the bit of the ingress port.
- R4: When the destination equals `own_mac`, `res_egress` is all zeros, `res_to_cpu` is 1 and `res_hit` is 0, whatever the table holds.
- R5: An unknown source address is bound to the ingress port in a free entry. The binding is used by lookups from the next accepted descriptor on, and not by the descriptor that created it.
- R6: A known source address that arrives on a different port has its entry rewritten to the new port. No second entry for the same address is ever created.
- R7: When the table holds DEPTH entries and an unknown source arrives, nothing is learned and `learn_drop_cnt` rises by one, saturating at its all-ones value. A known source on a full table updates its port and does not count.
- R8: After reset the table is empty, `res_valid` is 0 and `learn_drop_cnt` is 0.
- R9: All 48 address bits take part in each comparison: an address that differs from a stored one in bit 0 alone, or in bit 47 alone, does not match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_mac | input | 48 | Address of the switch itself |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_dst | input | 48 | Destination address of the frame |
| desc_src | input | 48 | Source address of the frame |
| desc_port | input | PORT_W | Ingress port number |
| res_valid | output | 1 | Result present this cycle |
| res_egress | output | NUM_PORTS | Egress port bitmap, bit i is port i |
| res_hit | output | 1 | Destination found in the table |
| res_to_cpu | output | 1 | Frame is for the switch itself |
| learn_drop_cnt | output | CNT_W | Count of source addresses lost to a full table |

## Verification
Every result is due in the cycle right after the descriptor's accepting edge, and the learning effect of a frame is visible to the descriptor accepted after it, so a model in the bench applies each accepted descriptor at the same rising edge as the design and the outputs are compared at the following falling edge. The drop counter moves at that same edge and is compared each cycle as well. Directed sequences cover a frame whose destination equals its own unknown source, an address moving between ports, single-bit differences at both ends of the address, and a full table that meets both a new and a known source.

// File: rtl/l2lf_pkg.sv
package l2lf_pkg;
   localparam int MAC_W = 48;
   typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/l2lf_match.sv
module l2lf_match
   import l2lf_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int PORT_W = 2,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  mac_t                          key,
   input  logic [DEPTH-1:0]              ent_vld,
   input  logic [DEPTH-1:0][MAC_W-1:0]   ent_mac,
   input  logic [DEPTH-1:0][PORT_W-1:0]  ent_port,
   output logic [DEPTH-1:0]              hit_vec,
   output logic                          hit,
   output logic [PORT_W-1:0]             hit_port,
   output logic [IDX_W-1:0]              hit_idx
);
   // one comparator per entry, all in parallel
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = ent_vld[g] && (ent_mac[g] == key);
   end

   assign hit = |hit_vec;

   // entries are unique, so an OR of the selected fields is a mux
   always_comb begin
      hit_port = '0;
      hit_idx  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_vec[i]) begin
            hit_port = hit_port | ent_port[i];
            hit_idx  = hit_idx | IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/l2lf_free_pick.sv
module l2lf_free_pick #(
   parameter int DEPTH = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [DEPTH-1:0] ent_vld,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);
   assign any_free = ~&ent_vld;

   // scan downward so the lowest empty slot is the one left standing
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!ent_vld[i]) free_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/l2_learn_fwd.sv
module l2_learn_fwd
   import l2lf_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int DEPTH     = 8,
   parameter int CNT_W     = 8,
   parameter bit SAT_DROP  = 1'b1,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAC_W-1:0]     own_mac,
   input  logic                 desc_valid,
   output logic                 desc_ready,
   input  logic [MAC_W-1:0]     desc_dst,
   input  logic [MAC_W-1:0]     desc_src,
   input  logic [PORT_W-1:0]    desc_port,
   output logic                 res_valid,
   output logic [NUM_PORTS-1:0] res_egress,
   output logic                 res_hit,
   output logic                 res_to_cpu,
   output logic [CNT_W-1:0]     learn_drop_cnt
);
   // elaboration-time parameter checks
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("l2_learn_fwd: NUM_PORTS must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("l2_learn_fwd: DEPTH must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("l2_learn_fwd: CNT_W must be at least 1");
   end

   // binding table
   logic [DEPTH-1:0]             tbl_vld;
   logic [DEPTH-1:0][MAC_W-1:0]  tbl_mac;
   logic [DEPTH-1:0][PORT_W-1:0] tbl_port;

   logic                 accept;
   logic [DEPTH-1:0]     dst_vec, src_vec;
   logic                 dst_hit, src_hit;
   logic [PORT_W-1:0]    dst_port, src_port_unused;
   logic [IDX_W-1:0]     dst_idx_unused, src_idx;
   logic                 any_free;
   logic [IDX_W-1:0]     free_idx;
   logic                 for_cpu;
   logic [NUM_PORTS-1:0] flood_bm, hit_bm, egress_nxt;
   logic                 drop_evt;

   assign desc_ready = 1'b1;
   assign accept     = desc_valid && desc_ready;

   l2lf_match #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_dst_look (
      .key      (desc_dst),
      .ent_vld  (tbl_vld),
      .ent_mac  (tbl_mac),
      .ent_port (tbl_port),
      .hit_vec  (dst_vec),
      .hit      (dst_hit),
      .hit_port (dst_port),
      .hit_idx  (dst_idx_unused)
   );

   l2lf_match #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_src_look (
      .key      (desc_src),
      .ent_vld  (tbl_vld),
      .ent_mac  (tbl_mac),
      .ent_port (tbl_port),
      .hit_vec  (src_vec),
      .hit      (src_hit),
      .hit_port (src_port_unused),
      .hit_idx  (src_idx)
   );

   l2lf_free_pick #(.DEPTH(DEPTH)) u_free (
      .ent_vld  (tbl_vld),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   // forwarding decision
   assign for_cpu  = (desc_dst == own_mac);
   assign hit_bm   = NUM_PORTS'(1) << dst_port;
   assign flood_bm = {NUM_PORTS{1'b1}} ^ (NUM_PORTS'(1) << desc_port);

   always_comb begin
      if (for_cpu)      egress_nxt = '0;
      else if (dst_hit) egress_nxt = hit_bm;
      else              egress_nxt = flood_bm;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_egress <= '0;
         res_hit    <= 1'b0;
         res_to_cpu <= 1'b0;
      end else begin
         res_valid <= accept;
         if (accept) begin
            res_egress <= egress_nxt;
            res_hit    <= dst_hit && !for_cpu;
            res_to_cpu <= for_cpu;
         end
      end
   end

   // learning: move a known source, insert an unknown one, else drop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_vld  <= '0;
         tbl_mac  <= '0;
         tbl_port <= '0;
      end else if (accept) begin
         if (src_hit) begin
            tbl_port[src_idx] <= desc_port;
         end else if (any_free) begin
            tbl_vld[free_idx]  <= 1'b1;
            tbl_mac[free_idx]  <= desc_src;
            tbl_port[free_idx] <= desc_port;
         end
      end
   end

   assign drop_evt = accept && !src_hit && !any_free;

   if (SAT_DROP) begin : g_sat_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  learn_drop_cnt <= '0;
         else if (drop_evt && (learn_drop_cnt != '1)) learn_drop_cnt <= learn_drop_cnt + 1'b1;
      end
      // R7
      drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> learn_drop_cnt >= $past(learn_drop_cnt));
   end else begin : g_wrap_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        learn_drop_cnt <= '0;
         else if (drop_evt) learn_drop_cnt <= learn_drop_cnt + 1'b1;
      end
   end

   // R1
   res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> res_valid);
   // R1
   res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !res_valid);
   // R2
   hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |-> ($countones(res_egress) == 1 && !res_to_cpu));
   // R3
   flood_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit && !res_to_cpu) |-> ($countones(res_egress) == NUM_PORTS - 1));
   // R4
   cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_to_cpu) |-> (res_egress == '0 && !res_hit));
   // R6
   unique_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dst_vec) && $onehot0(src_vec));
   // R7
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (learn_drop_cnt != $past(learn_drop_cnt)) |-> $past(&tbl_vld));
endmodule

// File: tb/l2_learn_fwd_test.sv
module l2_learn_fwd_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP    = 4;
   localparam int DEPTH = 8;
   localparam int CW    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [47:0]   own_mac;
   logic          desc_valid;
   logic          desc_ready;
   logic [47:0]   desc_dst, desc_src;
   logic [1:0]    desc_port;
   logic          res_valid;
   logic [NP-1:0] res_egress;
   logic          res_hit, res_to_cpu;
   logic [CW-1:0] learn_drop_cnt;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   string cur_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   l2_learn_fwd #(.NUM_PORTS(NP), .DEPTH(DEPTH), .CNT_W(CW), .SAT_DROP(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .own_mac(own_mac),
      .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_dst(desc_dst), .desc_src(desc_src), .desc_port(desc_port),
      .res_valid(res_valid), .res_egress(res_egress), .res_hit(res_hit),
      .res_to_cpu(res_to_cpu), .learn_drop_cnt(learn_drop_cnt)
   );

   // behavioural reference: a list of bindings with a first-free insert
   bit          m_vld [DEPTH];
   logic [47:0] m_mac [DEPTH];
   int          m_port[DEPTH];
   int          m_drop;
   bit          exp_valid;
   logic [NP-1:0] exp_eg;
   bit          exp_hit, exp_cpu;
   string       exp_tag;

   function automatic int find(logic [47:0] k);
      for (int i = 0; i < DEPTH; i++)
         if (m_vld[i] && m_mac[i] == k) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
         m_drop = 0;
         exp_valid = 1'b0;
      end else begin
         exp_valid = desc_valid;
         if (desc_valid) begin
            int di, si, fi;
            exp_tag = cur_tag;
            di = find(desc_dst);
            if (desc_dst == own_mac) begin
               exp_eg = '0; exp_cpu = 1'b1; exp_hit = 1'b0;
            end else if (di >= 0) begin
               exp_eg = NP'(1 << m_port[di]); exp_cpu = 1'b0; exp_hit = 1'b1;
            end else begin
               exp_eg = NP'(4'hF) & ~NP'(1 << int'(desc_port)); exp_cpu = 1'b0; exp_hit = 1'b0;
            end
            si = find(desc_src);
            if (si >= 0) m_port[si] = int'(desc_port);
            else begin
               fi = -1;
               for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) fi = i;
               if (fi >= 0) begin
                  m_vld[fi] = 1'b1; m_mac[fi] = desc_src; m_port[fi] = int'(desc_port);
               end else if (m_drop < (1 << CW) - 1) m_drop++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // compare every cycle, half a period after the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(res_valid == exp_valid, "R1", "res_valid", 64'(res_valid), 64'(exp_valid));
         chk(desc_ready == 1'b1, "R1", "desc_ready", 64'(desc_ready), 64'd1);
         chk(int'(learn_drop_cnt) == m_drop, "R7", "learn_drop_cnt", 64'(learn_drop_cnt), 64'(m_drop));
         if (exp_valid) begin
            chk(res_egress == exp_eg, exp_tag, "res_egress", 64'(res_egress), 64'(exp_eg));
            chk(res_hit == exp_hit, exp_tag, "res_hit", 64'(res_hit), 64'(exp_hit));
            chk(res_to_cpu == exp_cpu, exp_tag, "res_to_cpu", 64'(res_to_cpu), 64'(exp_cpu));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic frame(input logic [47:0] d, input logic [47:0] s, input int p, input string t);
      desc_valid = 1'b1;
      desc_dst   = d;
      desc_src   = s;
      desc_port  = p[1:0];
      cur_tag    = t;
      @(negedge clk);
      desc_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   localparam logic [47:0] OWN = 48'h02AA_BBCC_DD00;
   localparam logic [47:0] MA  = 48'h0000_0000_00A1;
   localparam logic [47:0] MB  = 48'h0011_2233_4455;
   localparam logic [47:0] MC  = 48'h00C0_FFEE_0001;
   localparam logic [47:0] MD  = 48'h00D0_0000_0D0D;
   localparam logic [47:0] ME  = 48'h00E0_1111_2222;

   initial begin
      rst_n = 1'b0;
      own_mac = OWN;
      desc_valid = 1'b0;
      desc_dst = '0; desc_src = '0; desc_port = '0;
      idle(3);
      rst_n = 1'b1;
      // R8 reset state
      chk(res_valid == 1'b0, "R8", "res_valid after reset", 64'(res_valid), 64'd0);
      chk(learn_drop_cnt == '0, "R8", "learn_drop_cnt after reset", 64'(learn_drop_cnt), 64'd0);
      idle(1);

      frame(MA, MB, 0, "R3");                       // unknown destination floods
      frame(MB, MC, 2, "R5");                       // B learned by the frame before
      frame(MB ^ 48'h1, MC, 2, "R9");               // bit 0 differs
      frame(MB ^ 48'h8000_0000_0000, MC, 1, "R9");  // bit 47 differs
      idle(2);
      frame(OWN, MD, 1, "R4");                      // own address, D learned
      frame(ME, ME, 3, "R5");                       // same-frame source not yet visible
      frame(ME, MA, 0, "R2");                       // E now known on port 3
      frame(MC, MB, 3, "R6");                       // B moves from port 0 to port 3
      frame(MB, MD, 1, "R6");                       // follows the move
      idle(1);
      // fill the table: B C D E A held, add three more
      for (int k = 0; k < 3; k++) frame(MA, 48'h0F00_0000_0000 + 48'(k), k, "R5");
      frame(MA, 48'h0BAD_0000_0001, 2, "R7");       // full: dropped
      frame(48'h0BAD_0000_0001, 48'h0BAD_0000_0002, 1, "R7"); // still unknown, dropped
      frame(MD, MC, 0, "R7");                       // known source on full table: moves, no count
      frame(MC, MA, 2, "R7");                       // C now on port 0
      frame(OWN, MB, 2, "R4");
      idle(3);
      for (int k = 0; k < 4; k++) frame(MB ^ 48'(k), MB, k, "R2");
      idle(2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule